// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one channel of a DMA engine. It copies a run of elements between a device address that never changes and a memory address that advances after each element. Software loads four channel words: device address, memory address, size and link. It then picks a run mode and pulses a start input. In single mode the channel runs directly from those loaded words. In chained mode the channel first fetches a 16-byte descriptor from memory at the link address and loads it into the same four words. It then moves that descriptor's data and, if the descriptor asks for it, carries on to the next descriptor in the list.

Every memory access, whether a descriptor fetch or a data element read or write, goes through one request port with a valid/ready handshake. Read data returns on a separate response strobe, after any number of cycles. The channel reports a coarse 2-bit activity state and raises one-cycle pulses for completion and for a bad size word. Forcing the run mode to off at any time stops the channel at once.

Top module: `dma_link_chan`

## Requirements
- R1: While reset is held and in the first cycle after it, state_o is 0, req_valid_o is low, and done_o and err_o are low.
- R2: In single mode the channel reads one source element and then writes it to the destination, once per element, for the number of elements given in the size word.
- R3: With dir_i = 1 the channel reads from the memory address and writes to the device address. With dir_i = 0 it reads from the device address and writes to the memory address. The device address never changes during a run.
- R4: Size word bits [13:12] select the element width: 3 selects 1 byte, 2 selects 2 bytes, 0 selects 4 bytes. req_bytes_o shows the width as 1, 2 or 4. The element count is size bits [9:0] for the 1- and 2-byte widths and size bits [10:0] for the 4-byte width. The memory address advances by the width after every element.
- R5: In chained mode the channel reads four words at P, P+4, P+8 and P+12, where P is the link word with bits [1:0] cleared. It loads them, in that order, as device address, memory address, size and link.
- R6: Link bits [1:0] are a code. Bit 1 set means continue with the descriptor at the link address with bits [1:0] cleared. Bit 1 clear means return to idle. Bit 0 set produces a done pulse after that descriptor's last write.
- R7: In single mode link bit 1 is ignored. The channel always returns to idle after the block, and bit 0 still controls done.
- R8: A width code of 1, or an element count of 0, raises err_o and returns the channel to idle without any data read or write.
- R9: state_o is 0 when idle, 1 while fetching a descriptor, 2 while waiting for an element's read data, and 3 while checking the size word or issuing element requests.
- R10: go_i has an effect only when the channel is idle and mode_i is 1 (chained) or 2 (single). A pulse while busy changes nothing.
- R11: mode_i = 0 while busy puts the channel into idle on the next cycle. No request is offered in the cycle that mode_i is 0, and no done pulse follows.
- R12: A host write (host_sel: 0 device address, 1 memory address, 2 size, 3 link) takes effect only while idle. Writes while busy are dropped.
- R13: done_o and err_o are single-cycle pulses that never occur together. done_o appears in the cycle after the final write handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Channel word write strobe |
| host_sel | input | 2 | Channel word select |
| host_wdata | input | 32 | Channel word write data |
| go_i | input | 1 | Start pulse |
| mode_i | input | 2 | Run mode: 0 off, 1 chained, 2 single |
| dir_i | input | 1 | Transfer direction, sampled at start |
| req_valid_o | output | 1 | Memory request valid |
| req_write_o | output | 1 | Request is a write |
| req_addr_o | output | 32 | Request byte address |
| req_wdata_o | output | 32 | Write data |
| req_bytes_o | output | 3 | Access size in bytes |
| req_ready_i | input | 1 | Request accepted |
| rsp_valid_i | input | 1 | Read data strobe |
| rsp_data_i | input | 32 | Read data |
| state_o | output | 2 | Channel activity state |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Bad size word pulse |

## Verification
The hardest case to reach from the ports is an abort that lands while a read is still outstanding. The stale read data then arrives after the channel has already gone idle, and it must not disturb the next run. The bench stalls the request port and delays read responses in a pseudo-random pattern, switches the mode to off partway through a long single-mode block, and then starts a new block. That new block must still produce exactly its expected writes. Chained runs mix follow and end codes with and without the interrupt bit, use three element widths, and leave junk in the low link bits, so both the descriptor fetch order and the done count are checked.

// File: rtl/dma_link_pkg.sv
package dma_link_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned CNT_W      = 11;
    localparam int unsigned DESC_WORDS = 4;
    localparam int unsigned WIDX_W     = $clog2(DESC_WORDS);
    localparam int unsigned SIZE_LO_W  = 14;

    localparam logic [1:0] SEL_DEV  = 2'd0;
    localparam logic [1:0] SEL_MEM  = 2'd1;
    localparam logic [1:0] SEL_SIZE = 2'd2;
    localparam logic [1:0] SEL_LINK = 2'd3;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_CHAIN  = 2'd1,
        MODE_SINGLE = 2'd2,
        MODE_RSVD   = 2'd3
    } run_mode_e;

    typedef enum logic [1:0] {
        CST_IDLE = 2'd0,
        CST_DESC = 2'd1,
        CST_WAIT = 2'd2,
        CST_XFER = 2'd3
    } chan_state_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FREQ,
        PH_FRSP,
        PH_CHECK,
        PH_RREQ,
        PH_RRSP,
        PH_WREQ
    } phase_e;

    typedef struct packed {
        logic [WORD_W-1:0] dev;
        logic [WORD_W-1:0] mem;
        logic [WORD_W-1:0] size;
        logic [WORD_W-1:0] link;
    } chan_regs_t;

    function automatic logic width_legal(input logic [1:0] code);
        return code != 2'd1;
    endfunction

    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        case (code)
            2'd3:    return 3'd1;
            2'd2:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] elem_count(input logic [SIZE_LO_W-1:0] sz);
        if (sz[13:12] == 2'd0)
            return sz[CNT_W-1:0];
        else
            return {1'b0, sz[CNT_W-2:0]};
    endfunction

    function automatic chan_state_e phase_to_state(input phase_e ph);
        case (ph)
            PH_IDLE:          return CST_IDLE;
            PH_FREQ, PH_FRSP: return CST_DESC;
            PH_RRSP:          return CST_WAIT;
            default:          return CST_XFER;
        endcase
    endfunction

endpackage

// File: rtl/dlc_regs.sv
module dlc_regs
    import dma_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              host_open,
    input  logic              fill_en,
    input  logic [1:0]        fill_sel,
    input  logic [WORD_W-1:0] fill_data,
    input  logic              mem_step,
    input  logic [2:0]        step_bytes,
    output chan_regs_t        regs_o
);

    logic [WORD_W-1:0] word_v [DESC_WORDS];

    for (genvar w = 0; w < DESC_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (fill_en && fill_sel == 2'(w)) begin
                q <= fill_data;
            end else if (host_we && host_open && host_sel == 2'(w)) begin
                q <= host_wdata;
            end else if (mem_step && SEL_MEM == 2'(w)) begin
                q <= q + {{(WORD_W-3){1'b0}}, step_bytes};
            end
        end
        assign word_v[w] = q;
    end

    assign regs_o.dev  = word_v[SEL_DEV];
    assign regs_o.mem  = word_v[SEL_MEM];
    assign regs_o.size = word_v[SEL_SIZE];
    assign regs_o.link = word_v[SEL_LINK];

endmodule

// File: rtl/dlc_seq.sv
module dlc_seq
    import dma_link_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic [1:0]           mode,
    input  logic                 dir,
    input  logic [SIZE_LO_W-1:0] size_lo,
    input  logic [WORD_W-1:0]    link_w,
    input  logic                 req_ready,
    input  logic                 rsp_valid,
    input  logic [WORD_W-1:0]    rsp_data,
    output phase_e               phase,
    output logic [WIDX_W-1:0]    widx,
    output logic [WORD_W-1:0]    ptr,
    output logic [WORD_W-1:0]    hold,
    output logic                 dir_q_o,
    output logic                 abort,
    output logic                 fill_en,
    output logic                 mem_step,
    output logic                 done,
    output logic                 err
);

    phase_e            phase_q, phase_d;
    logic [WIDX_W-1:0] widx_q, widx_d;
    logic [WORD_W-1:0] ptr_q, ptr_d;
    logic [WORD_W-1:0] hold_q, hold_d;
    logic [CW-1:0]     remain_q, remain_d;
    logic              chain_q, chain_d;
    logic              dir_q, dir_d;
    logic              done_q, done_d;
    logic              err_q, err_d;

    logic              size_ok;
    logic [CW-1:0]     count;
    logic [WORD_W-1:0] link_ptr;
    logic              start_ok;

    assign size_ok  = width_legal(size_lo[13:12]);
    assign count    = CW'(elem_count(size_lo));
    assign link_ptr = {link_w[WORD_W-1:2], 2'b00};
    assign abort    = (phase_q != PH_IDLE) && (mode == MODE_OFF);
    assign start_ok = go && (mode == MODE_CHAIN || mode == MODE_SINGLE);

    always_comb begin
        phase_d  = phase_q;
        widx_d   = widx_q;
        ptr_d    = ptr_q;
        hold_d   = hold_q;
        remain_d = remain_q;
        chain_d  = chain_q;
        dir_d    = dir_q;
        done_d   = 1'b0;
        err_d    = 1'b0;
        fill_en  = 1'b0;
        mem_step = 1'b0;
        if (abort) begin
            phase_d = PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_ok) begin
                        dir_d   = dir;
                        chain_d = (mode == MODE_CHAIN);
                        if (mode == MODE_CHAIN) begin
                            ptr_d   = link_ptr;
                            widx_d  = '0;
                            phase_d = PH_FREQ;
                        end else begin
                            phase_d = PH_CHECK;
                        end
                    end
                end
                PH_FREQ: begin
                    if (req_ready) phase_d = PH_FRSP;
                end
                PH_FRSP: begin
                    if (rsp_valid) begin
                        fill_en = 1'b1;
                        if (widx_q == WIDX_W'(DESC_WORDS - 1)) begin
                            phase_d = PH_CHECK;
                        end else begin
                            widx_d  = widx_q + 1'b1;
                            phase_d = PH_FREQ;
                        end
                    end
                end
                PH_CHECK: begin
                    if (!size_ok || count == '0) begin
                        err_d   = 1'b1;
                        phase_d = PH_IDLE;
                    end else begin
                        remain_d = count;
                        phase_d  = PH_RREQ;
                    end
                end
                PH_RREQ: begin
                    if (req_ready) phase_d = PH_RRSP;
                end
                PH_RRSP: begin
                    if (rsp_valid) begin
                        hold_d  = rsp_data;
                        phase_d = PH_WREQ;
                    end
                end
                PH_WREQ: begin
                    if (req_ready) begin
                        mem_step = 1'b1;
                        if (remain_q == CW'(1)) begin
                            done_d = link_w[0];
                            if (chain_q && link_w[1]) begin
                                ptr_d   = link_ptr;
                                widx_d  = '0;
                                phase_d = PH_FREQ;
                            end else begin
                                phase_d = PH_IDLE;
                            end
                        end else begin
                            remain_d = remain_q - 1'b1;
                            phase_d  = PH_RREQ;
                        end
                    end
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            widx_q   <= '0;
            ptr_q    <= '0;
            hold_q   <= '0;
            remain_q <= '0;
            chain_q  <= 1'b0;
            dir_q    <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            widx_q   <= widx_d;
            ptr_q    <= ptr_d;
            hold_q   <= hold_d;
            remain_q <= remain_d;
            chain_q  <= chain_d;
            dir_q    <= dir_d;
            done_q   <= done_d;
            err_q    <= err_d;
        end
    end

    assign phase   = phase_q;
    assign widx    = widx_q;
    assign ptr     = ptr_q;
    assign hold    = hold_q;
    assign dir_q_o = dir_q;
    assign done    = done_q;
    assign err     = err_q;

endmodule

// File: rtl/dlc_bus.sv
module dlc_bus
    import dma_link_pkg::*;
(
    input  phase_e            phase,
    input  logic [WIDX_W-1:0] widx,
    input  logic [WORD_W-1:0] ptr,
    input  logic [WORD_W-1:0] dev_addr,
    input  logic [WORD_W-1:0] mem_addr,
    input  logic [1:0]        width_code,
    input  logic [WORD_W-1:0] hold,
    input  logic              dir_q,
    input  logic              abort,
    output logic              req_valid,
    output logic              req_write,
    output logic [WORD_W-1:0] req_addr,
    output logic [WORD_W-1:0] req_wdata,
    output logic [2:0]        req_bytes
);

    logic [WORD_W-1:0] src_addr;
    logic [WORD_W-1:0] dst_addr;

    assign src_addr = dir_q ? mem_addr : dev_addr;
    assign dst_addr = dir_q ? dev_addr : mem_addr;

    always_comb begin
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        req_bytes = 3'd4;
        case (phase)
            PH_FREQ: begin
                req_valid = 1'b1;
                req_addr  = ptr + {{(WORD_W-WIDX_W-2){1'b0}}, widx, 2'b00};
            end
            PH_RREQ: begin
                req_valid = 1'b1;
                req_addr  = src_addr;
                req_bytes = width_bytes(width_code);
            end
            PH_WREQ: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_addr  = dst_addr;
                req_wdata = hold;
                req_bytes = width_bytes(width_code);
            end
            default: ;
        endcase
        if (abort) req_valid = 1'b0;
    end

endmodule

// File: rtl/dma_link_chan.sv
module dma_link_chan
    import dma_link_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [1:0]  host_sel,
    input  logic [31:0] host_wdata,
    input  logic        go_i,
    input  logic [1:0]  mode_i,
    input  logic        dir_i,
    output logic        req_valid_o,
    output logic        req_write_o,
    output logic [31:0] req_addr_o,
    output logic [31:0] req_wdata_o,
    output logic [2:0]  req_bytes_o,
    input  logic        req_ready_i,
    input  logic        rsp_valid_i,
    input  logic [31:0] rsp_data_i,
    output logic [1:0]  state_o,
    output logic        done_o,
    output logic        err_o
);

    chan_regs_t        regs;
    phase_e            phase;
    logic [WIDX_W-1:0] widx;
    logic [WORD_W-1:0] ptr;
    logic [WORD_W-1:0] hold;
    logic              dir_q;
    logic              abort;
    logic              fill_en;
    logic              mem_step;
    logic              unused_size_hi;

    assign unused_size_hi = ^regs.size[WORD_W-1:SIZE_LO_W];

    dlc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_open  (phase == PH_IDLE),
        .fill_en    (fill_en),
        .fill_sel   (widx),
        .fill_data  (rsp_data_i),
        .mem_step   (mem_step),
        .step_bytes (width_bytes(regs.size[13:12])),
        .regs_o     (regs)
    );

    dlc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go_i),
        .mode      (mode_i),
        .dir       (dir_i),
        .size_lo   (regs.size[SIZE_LO_W-1:0]),
        .link_w    (regs.link),
        .req_ready (req_ready_i),
        .rsp_valid (rsp_valid_i),
        .rsp_data  (rsp_data_i),
        .phase     (phase),
        .widx      (widx),
        .ptr       (ptr),
        .hold      (hold),
        .dir_q_o   (dir_q),
        .abort     (abort),
        .fill_en   (fill_en),
        .mem_step  (mem_step),
        .done      (done_o),
        .err       (err_o)
    );

    dlc_bus u_bus (
        .phase      (phase),
        .widx       (widx),
        .ptr        (ptr),
        .dev_addr   (regs.dev),
        .mem_addr   (regs.mem),
        .width_code (regs.size[13:12]),
        .hold       (hold),
        .dir_q      (dir_q),
        .abort      (abort),
        .req_valid  (req_valid_o),
        .req_write  (req_write_o),
        .req_addr   (req_addr_o),
        .req_wdata  (req_wdata_o),
        .req_bytes  (req_bytes_o)
    );

    assign state_o = phase_to_state(phase);

endmodule

// File: rtl/dma_link_chan_chk.sv
module dma_link_chan_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  mode_i,
    input logic        req_valid_o,
    input logic        req_write_o,
    input logic [31:0] req_addr_o,
    input logic        req_ready_i,
    input logic [1:0]  state_o,
    input logic        done_o,
    input logic        err_o
);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        state_o == 2'd0 |-> !req_valid_o);

    // R9
    wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        state_o == 2'd2 |-> !req_valid_o);

    // R5
    desc_read_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd1 && req_valid_o) |-> (!req_write_o && req_addr_o[1:0] == 2'b00));

    // R9
    write_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && req_write_o) |-> state_o == 2'd3);

    // R13
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

    // R13
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(req_valid_o && req_write_o && req_ready_i));

    // R8
    err_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> state_o == 2'd0);

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o != 2'd0 && mode_i == 2'd0) |=> (state_o == 2'd0 && !done_o));

    // R11
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'd0 |-> !req_valid_o);

endmodule

bind dma_link_chan dma_link_chan_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .req_valid_o (req_valid_o),
    .req_write_o (req_write_o),
    .req_addr_o  (req_addr_o),
    .req_ready_i (req_ready_i),
    .state_o     (state_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/dma_link_chan_bench.sv
module dma_link_chan_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic        go_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic        dir_i = 1'b0;
    logic        req_valid_o, req_write_o;
    logic [31:0] req_addr_o, req_wdata_o;
    logic [2:0]  req_bytes_o;
    logic        req_ready_i = 1'b0;
    logic        rsp_valid_i = 1'b0;
    logic [31:0] rsp_data_i = '0;
    logic [1:0]  state_o;
    logic        done_o, err_o;

    always #5 clk = ~clk;

    dma_link_chan u_dma_link_chan (.*);

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic [2:0]  bytes;
        string       tag;
    } wr_t;

    wr_t         exp_wr[$];
    logic [31:0] exp_desc[$];
    logic [31:0] dmem [int unsigned];

    int   n_cmp = 0, n_bad = 0;
    int   done_cnt = 0, err_cnt = 0, data_rd = 0;
    bit   lenient = 0;
    bit   saw_st [4];
    logic [7:0]  lfsr = 8'h5B;
    bit          rsp_pend = 0;
    int          rsp_wait = 0;
    logic [31:0] rsp_hold = '0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[31:16] ^ 16'hC3A5};
    endfunction

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (dmem.exists(a)) return dmem[a];
        return pat(a);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model and monitor
    always @(negedge clk) begin
        if (rst) begin
            req_ready_i = 1'b0;
            rsp_valid_i = 1'b0;
            rsp_pend    = 0;
        end else begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            req_ready_i = lfsr[0] | lfsr[1];
            rsp_valid_i = 1'b0;
            if (rsp_pend) begin
                if (rsp_wait == 0) begin
                    rsp_valid_i = 1'b1;
                    rsp_data_i  = rsp_hold;
                    rsp_pend    = 0;
                end else begin
                    rsp_wait--;
                end
            end
            #1;
            if (done_o) done_cnt++;
            if (err_o) err_cnt++;
            saw_st[state_o] = 1;
            if (req_valid_o && req_ready_i) begin
                if (!req_write_o) begin
                    rsp_pend = 1;
                    rsp_hold = rd(req_addr_o);
                    rsp_wait = int'(lfsr[2]);
                    if (state_o == 2'd1) begin
                        if (exp_desc.size() == 0) begin
                            chk(0, "R5", "unexpected descriptor read", req_addr_o, 32'h0);
                        end else begin
                            logic [31:0] ea;
                            ea = exp_desc.pop_front();
                            chk(req_addr_o == ea, "R5", "descriptor read addr", req_addr_o, ea);
                        end
                    end else begin
                        data_rd++;
                    end
                end else begin
                    if (exp_wr.size() == 0) begin
                        if (!lenient) chk(0, "R2", "unexpected write", req_addr_o, 32'h0);
                    end else begin
                        wr_t e;
                        e = exp_wr.pop_front();
                        chk(req_addr_o == e.addr, e.tag, "write addr", req_addr_o, e.addr);
                        chk(req_wdata_o == e.data, e.tag, "write data", req_wdata_o, e.data);
                        chk(req_bytes_o == e.bytes, e.tag, "write bytes",
                            {29'd0, req_bytes_o}, {29'd0, e.bytes});
                    end
                end
            end
        end
    end

    task automatic host_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic load_regs(input logic [31:0] dv, input logic [31:0] mm,
                             input logic [31:0] sz, input logic [31:0] lk);
        host_write(2'd0, dv);
        host_write(2'd1, mm);
        host_write(2'd2, sz);
        host_write(2'd3, lk);
    endtask

    task automatic start(input logic [1:0] md, input logic dr);
        @(negedge clk);
        mode_i = md; dir_i = dr; go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk); #2;
        while (state_o != 2'd0) begin
            @(negedge clk); #2;
        end
    endtask

    // scoreboard driver: expected writes for one block
    task automatic expect_block(input logic [31:0] dv, input logic [31:0] mm,
                                input logic [31:0] sz, input logic dr, input string tag);
        int w, n;
        case (sz[13:12])
            2'd3:    w = 1;
            2'd2:    w = 2;
            default: w = 4;
        endcase
        n = (sz[13:12] == 2'd0) ? int'(sz[10:0]) : int'(sz[9:0]);
        for (int i = 0; i < n; i++) begin
            wr_t e;
            logic [31:0] ma;
            ma = mm + 32'(i * w);
            e.addr  = dr ? dv : ma;
            e.data  = rd(dr ? ma : dv);
            e.bytes = 3'(w);
            e.tag   = tag;
            exp_wr.push_back(e);
        end
    endtask

    task automatic put_desc(input logic [31:0] b, input logic [31:0] dv, input logic [31:0] mm,
                            input logic [31:0] sz, input logic [31:0] nx);
        dmem[b] = dv; dmem[b + 4] = mm; dmem[b + 8] = sz; dmem[b + 12] = nx;
        for (int k = 0; k < 4; k++) exp_desc.push_back(b + 32'(4 * k));
    endtask

    task automatic tests();
        int d0, e0, r0, quiet;
        repeat (4) @(negedge clk);
        #2;
        // R1 reset state
        chk(state_o == 2'd0, "R1", "state in reset", {30'd0, state_o}, 0);
        chk(!req_valid_o, "R1", "req_valid in reset", {31'd0, req_valid_o}, 0);
        chk(!done_o && !err_o, "R1", "pulses in reset", {30'd0, done_o, err_o}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        chk(state_o == 2'd0 && !req_valid_o, "R1", "idle after reset", {30'd0, state_o}, 0);

        // R2 R3 R4: single, mem->dev, 4-byte x3, end with irq
        load_regs(32'h4000_0010, 32'h0010_0000, 32'h0000_0003, 32'h0000_0001);
        expect_block(32'h4000_0010, 32'h0010_0000, 32'h0000_0003, 1'b1, "R3");
        d0 = done_cnt;
        start(2'd2, 1'b1);
        wait_idle();
        chk(exp_wr.size() == 0, "R2", "writes left", exp_wr.size(), 0);
        chk(done_cnt - d0 == 1, "R6", "done after irq end", done_cnt - d0, 1);

        // R3 R4: dev->mem, 1-byte x2, end without irq
        load_regs(32'h4000_0020, 32'h0020_0001, 32'h0000_3002, 32'h0000_0000);
        expect_block(32'h4000_0020, 32'h0020_0001, 32'h0000_3002, 1'b0, "R4");
        d0 = done_cnt;
        start(2'd2, 1'b0);
        wait_idle();
        chk(exp_wr.size() == 0, "R4", "writes left", exp_wr.size(), 0);
        chk(done_cnt - d0 == 0, "R6", "no done without irq bit", done_cnt - d0, 0);

        // R4 count mask, R7 follow ignored in single mode
        host_write(2'd1, 32'h0030_0000);
        host_write(2'd2, 32'h0000_2C03);
        host_write(2'd3, 32'h0000_8003);
        expect_block(32'h4000_0020, 32'h0030_0000, 32'h0000_2003, 1'b1, "R7");
        d0 = done_cnt;
        start(2'd2, 1'b1);
        wait_idle();
        chk(exp_wr.size() == 0, "R4", "masked count writes left", exp_wr.size(), 0);
        chk(done_cnt - d0 == 1, "R7", "done in single mode", done_cnt - d0, 1);

        // R10 R12: busy host writes and go pulse ignored; mem continues at 0x300006
        host_write(2'd2, 32'h0000_0008);
        expect_block(32'h4000_0020, 32'h0030_0006, 32'h0000_0008, 1'b1, "R12");
        d0 = done_cnt;
        start(2'd2, 1'b1);
        host_write(2'd0, 32'hDEAD_0000);
        host_write(2'd3, 32'h0000_0000);
        @(negedge clk);
        mode_i = 2'd1; go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
        wait_idle();
        chk(exp_wr.size() == 0, "R10", "busy go ignored", exp_wr.size(), 0);
        chk(done_cnt - d0 == 1, "R12", "link kept while busy", done_cnt - d0, 1);

        // R5 R6 R9: chain of three descriptors, dev->mem
        put_desc(32'h0800_0000, 32'h5000_0000, 32'h0110_0000, 32'h0000_0002, 32'h0800_0102);
        put_desc(32'h0800_0100, 32'h5000_0004, 32'h0120_0000, 32'h0000_3003, 32'h0800_0203);
        put_desc(32'h0800_0200, 32'h5000_0008, 32'h0130_0000, 32'h0000_2001, 32'h0900_0001);
        expect_block(32'h5000_0000, 32'h0110_0000, 32'h0000_0002, 1'b0, "R5");
        expect_block(32'h5000_0004, 32'h0120_0000, 32'h0000_3003, 1'b0, "R6");
        expect_block(32'h5000_0008, 32'h0130_0000, 32'h0000_2001, 1'b0, "R6");
        host_write(2'd3, 32'h0800_0003);
        for (int s = 0; s < 4; s++) saw_st[s] = 0;
        d0 = done_cnt; e0 = err_cnt;
        start(2'd1, 1'b0);
        wait_idle();
        chk(exp_desc.size() == 0, "R5", "descriptor reads left", exp_desc.size(), 0);
        chk(exp_wr.size() == 0, "R6", "chain writes left", exp_wr.size(), 0);
        chk(done_cnt - d0 == 2, "R6", "done count over chain", done_cnt - d0, 2);
        chk(err_cnt == e0, "R13", "no err in chain", err_cnt - e0, 0);
        chk(saw_st[1] && saw_st[2] && saw_st[3], "R9", "states seen",
            {29'd0, saw_st[1], saw_st[2], saw_st[3]}, 32'h7);

        // R8: reserved width code in single mode
        load_regs(32'h4000_0040, 32'h0040_0000, 32'h0000_1005, 32'h0000_0001);
        d0 = done_cnt; e0 = err_cnt; r0 = data_rd;
        start(2'd2, 1'b1);
        wait_idle();
        chk(err_cnt - e0 == 1, "R8", "err on reserved width", err_cnt - e0, 1);
        chk(done_cnt == d0, "R8", "no done on error", done_cnt - d0, 0);
        chk(data_rd == r0, "R8", "no data read on error", data_rd - r0, 0);

        // R8: zero count in chained descriptor
        put_desc(32'h0800_0300, 32'h5000_0010, 32'h0140_0000, 32'h0000_0000, 32'h0000_0003);
        host_write(2'd3, 32'h0800_0300);
        e0 = err_cnt; r0 = data_rd;
        start(2'd1, 1'b0);
        wait_idle();
        chk(err_cnt - e0 == 1, "R8", "err on zero count", err_cnt - e0, 1);
        chk(data_rd == r0, "R8", "no data read on zero count", data_rd - r0, 0);
        chk(exp_desc.size() == 0, "R5", "zero-count descriptor fetched", exp_desc.size(), 0);

        // R11: abort mid-block
        load_regs(32'h4000_0050, 32'h0050_0000, 32'h0000_0014, 32'h0000_0001);
        expect_block(32'h4000_0050, 32'h0050_0000, 32'h0000_0014, 1'b1, "R11");
        lenient = 1;
        d0 = done_cnt;
        start(2'd2, 1'b1);
        repeat (15) @(negedge clk);
        mode_i = 2'd0;
        @(negedge clk); #2;
        chk(state_o == 2'd0, "R11", "idle after abort", {30'd0, state_o}, 0);
        chk(exp_wr.size() > 0, "R11", "abort before end", exp_wr.size(), 1);
        quiet = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk); #2;
            if (req_valid_o) quiet++;
        end
        chk(quiet == 0, "R11", "no requests after abort", quiet, 0);
        chk(done_cnt == d0, "R11", "no done after abort", done_cnt - d0, 0);
        exp_wr.delete();
        lenient = 0;

        // restart after abort
        load_regs(32'h4000_0060, 32'h0060_0000, 32'h0000_0001, 32'h0000_0001);
        expect_block(32'h4000_0060, 32'h0060_0000, 32'h0000_0001, 1'b1, "R11");
        d0 = done_cnt;
        start(2'd2, 1'b1);
        wait_idle();
        chk(exp_wr.size() == 0, "R11", "restart writes left", exp_wr.size(), 0);
        chk(done_cnt - d0 == 1, "R13", "done once after restart", done_cnt - d0, 1);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            tests();
            begin
                repeat (50000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual hung expected finished");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule